// File: doc/BRIEF.md
# Serial Configuration Clock Master with Daisy-Chain Pass-Through

This block is the master side of a serial configuration loader. Once its start input shows a genuine low-to-high transition, it generates a configuration clock (`cclk`). On every rising edge of that clock it takes one bit from the serial memory data line. The first `CFG_BITS` bits are the block's own configuration data. They are packed most-significant-bit first into `WORD_W`-bit words, and each word is presented with a one-cycle valid strobe.

An 8-bit clock-rate field sits at a fixed position inside that data. Until the field has been received, the clock runs at a parameterised default rate. From the system clock edge after the field's last bit is taken, the new rate applies. Once the block's own data is complete, further serial bits are either forwarded to a daisy-chain output for downstream devices or dropped, depending on a parameter. A completion input is synchronised to the system clock. After it is seen high, the block keeps the clock running for a fixed number of extra cycles (more than 100) and then parks the clock low.

All timing is expressed in system clock cycles. A half-period of the configuration clock lasts a whole number of system cycles, held in an 8-bit divider register.

Top module: `cfg_serial_master`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `cclk`, `dout` and `word_valid` are 0, and the divider holds `DIV_DEFAULT`.
- R2: `cclk` stays low until `init_n` has been sampled low and then high after reset. A level that is already high when reset is released does not start the clock.
- R3: `di` is sampled when `cclk` rises. Stream bit 0 is the first bit sampled. Each group of `WORD_W` consecutive bits among the first `CFG_BITS` appears on `word_data` with the earliest bit in the MSB, together with a one-cycle `word_valid` pulse. No word is produced after bit `CFG_BITS-1`.
- R4: Before a rate field has been loaded, `cclk` stays high and low for `DIV_DEFAULT` system cycles each.
- R5: Stream bits `RATE_POS` to `RATE_POS+7` form the rate value, earliest bit as MSB. It becomes the new half-period from the system edge after its last bit is taken. A value of 0 is treated as 1.
- R6: With `BYPASS_EN=1`, a bit sampled on a rise at or after stream position `CFG_BITS` is driven on `dout` from the next falling edge of `cclk` until the falling edge after that. `dout` changes only with a falling edge of `cclk`.
- R7: `dout` is 0 until the block's own `CFG_BITS` bits have all been taken.
- R8: With `BYPASS_EN=0`, bits after the block's own data have no effect: `dout` stays 0 and no word is produced.
- R9: `done_in` passes through two synchronising flops. After that, `cclk` completes `TAIL_CYCLES` (more than 100) further full periods, then stops low and stays low until reset.
- R10: A reset in the middle of operation restores the default divider and clears the bit, word and tail counters, so the next start behaves like the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_n | input | 1 | Start request; a low-to-high transition starts the configuration clock |
| done_in | input | 1 | Asynchronous configuration-complete indication |
| di | input | 1 | Serial data from the configuration memory |
| cclk | output | 1 | Generated configuration clock |
| dout | output | 1 | Daisy-chain serial output for downstream devices |
| word_data | output | WORD_W | Last completed word of the block's own data |
| word_valid | output | 1 | One-cycle strobe marking a new `word_data` |

## Verification
The bench goes after these corner cases:

- **Start edge.** It holds `init_n` high through a reset release. A design that starts on the level rather than the edge would toggle `cclk` there.
- **Clock rate.** It measures every high phase of `cclk`. A design that applied the rate field early or late, or that ignored the clamp, would show the wrong count around stream bit 16. An all-zero stream after a mid-run reset checks both the restored default and the zero-to-one clamp.
- **Bypass timing.** Forwarded bits are compared one rising edge late. A design that forwarded the final own bit, or that updated `dout` on the rising edge, would fail here.
- **Ignored traffic.** A second instance without bypass must keep `dout` at 0.
- **Tail length.** The number of rises after `done_in` must fall in a narrow window. A counter that was off by many cycles, or a clock that never stops, would land outside it.

// File: rtl/cfg_ser_pkg.sv
// Package: shared constants and types for the serial configuration master.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_ser_pkg;
    localparam int RATE_W = 8;
    typedef logic [RATE_W-1:0] rate_t;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } run_state_e;
endpackage

// File: rtl/cfg_cclk_gen.sv
// Module: configuration clock generator.
// Produces cclk with a programmable half-period (in system cycles) held in
// an 8-bit divider; emits one-cycle rise/fall pulses in the cycle whose edge
// flips cclk. Assumes run drops only from the top controller; a high phase
// in progress always completes so cclk parks low.
module cfg_cclk_gen
    import cfg_ser_pkg::*;
#(
    parameter int DIV_DEFAULT = 10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  rate_we,
    input  rate_t rate_val,
    output logic  cclk,
    output logic  rise_p,
    output logic  fall_p
);
    localparam rate_t DIV_INIT = rate_t'(DIV_DEFAULT);

    rate_t div_q;
    rate_t cnt_q;
    logic  cclk_q;
    logic  active;
    logic  tick;

    // Divider register: default after reset, replaced by a loaded rate field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_INIT;
        end else if (rate_we) begin
            div_q <= (rate_val == '0) ? rate_t'(1) : rate_val;
        end
    end

    // Edge decisions: a half-period ends when the count reaches the divider.
    always_comb begin
        active = run || cclk_q;
        tick   = (cnt_q >= (div_q - rate_t'(1)));
        rise_p = run && !cclk_q && tick;
        fall_p = cclk_q && tick;
    end

    // Half-period counter and clock flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
        end else if (!active) begin
            cnt_q  <= '0;
        end else if (rise_p || fall_p) begin
            cnt_q  <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            cnt_q  <= cnt_q + rate_t'(1);
        end
    end

    assign cclk = cclk_q;

    // R2
    cclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cclk_q) |=> !cclk_q);

    // R5
    rate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_we |=> (div_q != '0) && (div_q == (($past(rate_val) == '0) ? rate_t'(1) : $past(rate_val))));

    // R4
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_q != $past(cclk_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/cfg_bit_loader.sv
// Module: own-data loader.
// Shifts di in on each cclk rise until CFG_BITS bits are taken, emits
// WORD_W-bit words MSB-first with a one-cycle strobe, and extracts the
// 8-bit rate field at stream position RATE_POS. Assumes rise_p pulses are
// at least two system cycles apart and WORD_W >= 2.
module cfg_bit_loader
    import cfg_ser_pkg::*;
#(
    parameter int CFG_BITS = 32,
    parameter int WORD_W   = 8,
    parameter int RATE_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_p,
    input  logic              di,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              rate_we,
    output rate_t             rate_val,
    output logic              own_done
);
    localparam int CNT_W    = $clog2(CFG_BITS + 1);
    localparam int WC_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int RATE_END = RATE_POS + RATE_W - 1;

    logic [CNT_W-1:0]  bitcnt_q;
    logic [WC_W-1:0]   wcnt_q;
    logic [WORD_W-1:0] word_sh_q;
    logic              take;
    logic              word_end;

    assign own_done = (bitcnt_q == CNT_W'(CFG_BITS));
    assign take     = rise_p && !own_done;
    assign word_end = (wcnt_q == WC_W'(WORD_W - 1));

    // Bit counter and word shift register for own data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            wcnt_q     <= '0;
            word_sh_q  <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (take) begin
                bitcnt_q  <= bitcnt_q + CNT_W'(1);
                word_sh_q <= {word_sh_q[WORD_W-2:0], di};
                wcnt_q    <= word_end ? '0 : wcnt_q + WC_W'(1);
                if (word_end) begin
                    word_data  <= {word_sh_q[WORD_W-2:0], di};
                    word_valid <= 1'b1;
                end
            end
        end
    end

    // Rate field extraction, present only when the field lies inside own data.
    generate
        if (RATE_END < CFG_BITS) begin : g_rate
            rate_t rate_sh_q;
            // Shift the last 8 bits and publish them when the field's last bit lands.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rate_sh_q <= '0;
                    rate_val  <= '0;
                    rate_we   <= 1'b0;
                end else begin
                    rate_we <= 1'b0;
                    if (take) begin
                        rate_sh_q <= {rate_sh_q[RATE_W-2:0], di};
                        if (bitcnt_q == CNT_W'(RATE_END)) begin
                            rate_val <= {rate_sh_q[RATE_W-2:0], di};
                            rate_we  <= 1'b1;
                        end
                    end
                end
            end
        end else begin : g_no_rate
            assign rate_val = '0;
            assign rate_we  = 1'b0;
        end
    endgenerate

    // R3
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && !own_done) |=> (bitcnt_q == $past(bitcnt_q) + CNT_W'(1)));

    // R8
    no_word_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_done && $past(own_done)) |-> !word_valid);
endmodule

// File: rtl/cfg_done_tail.sv
// Module: completion synchroniser and post-completion cycle counter.
// Two flops bring done_in into the clk domain; after that, completed cclk
// periods (fall pulses) are counted and tail_expired latches at TAIL_CYCLES.
// Assumes TAIL_CYCLES >= 1; tail_expired holds until reset.
module cfg_done_tail #(
    parameter int TAIL_CYCLES = 101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_in,
    input  logic fall_p,
    output logic tail_expired
);
    localparam int TC_W = $clog2(TAIL_CYCLES + 1);

    logic            meta_q;
    logic            done_s_q;
    logic [TC_W-1:0] tcnt_q;

    // Two-flop synchroniser for the asynchronous completion input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            done_s_q <= 1'b0;
        end else begin
            meta_q   <= done_in;
            done_s_q <= meta_q;
        end
    end

    // Count completed clock periods after completion; latch expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q       <= '0;
            tail_expired <= 1'b0;
        end else if (done_s_q && !tail_expired && fall_p) begin
            tcnt_q <= tcnt_q + TC_W'(1);
            if (tcnt_q == TC_W'(TAIL_CYCLES - 1)) begin
                tail_expired <= 1'b1;
            end
        end
    end

    // R9
    tail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_expired |=> tail_expired);

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_s_q) |-> $past(done_in, 2));
endmodule

// File: rtl/cfg_bypass.sv
// Module: daisy-chain forwarding stage.
// When enabled, each bit taken on a cclk rise after own data is complete is
// held and driven on dout at the following cclk fall. When disabled, dout is
// tied low. Assumes rise/fall pulses come from the same clock generator.
module cfg_bypass #(
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_p,
    input  logic fall_p,
    input  logic own_done,
    input  logic di,
    output logic dout
);
    generate
        if (BYPASS_EN) begin : g_fwd
            logic hold_q;
            logic dout_q;
            // Capture on rise, present on the following fall.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= 1'b0;
                    dout_q <= 1'b0;
                end else begin
                    if (rise_p && own_done) begin
                        hold_q <= di;
                    end
                    if (fall_p && own_done) begin
                        dout_q <= hold_q;
                    end
                end
            end
            assign dout = dout_q;

            // R7
            idle_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !own_done |-> (dout == 1'b0));

            // R6
            dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !fall_p |=> $stable(dout));
        end else begin : g_drop
            assign dout = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cfg_serial_master.sv
// Module: serial configuration master (top).
// Waits for a low-to-high start transition, runs the configuration clock,
// loads own data, forwards later bits when bypass is enabled, and stops the
// clock a fixed number of periods after completion is seen. Assumes init_n
// is synchronous to clk; done_in may be asynchronous.
module cfg_serial_master
    import cfg_ser_pkg::*;
#(
    parameter int DIV_DEFAULT = 10,
    parameter int CFG_BITS    = 32,
    parameter int WORD_W      = 8,
    parameter int RATE_POS    = 8,
    parameter int TAIL_CYCLES = 101,
    parameter bit BYPASS_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              done_in,
    input  logic              di,
    output logic              cclk,
    output logic              dout,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);
    run_state_e state_q;
    logic       init_q;
    logic       run;
    logic       rise_p;
    logic       fall_p;
    logic       rate_we;
    rate_t      rate_val;
    logic       own_done;
    logic       tail_expired;

    // Start-edge detector and run/stop controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q  <= 1'b1;
            state_q <= ST_IDLE;
        end else begin
            init_q <= init_n;
            case (state_q)
                ST_IDLE: if (init_n && !init_q) state_q <= ST_RUN;
                ST_RUN:  if (tail_expired)      state_q <= ST_STOP;
                default: state_q <= ST_STOP;
            endcase
        end
    end

    assign run = (state_q == ST_RUN);

    cfg_cclk_gen #(.DIV_DEFAULT(DIV_DEFAULT)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate_we  (rate_we),
        .rate_val (rate_val),
        .cclk     (cclk),
        .rise_p   (rise_p),
        .fall_p   (fall_p)
    );

    cfg_bit_loader #(
        .CFG_BITS (CFG_BITS),
        .WORD_W   (WORD_W),
        .RATE_POS (RATE_POS)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_p     (rise_p),
        .di         (di),
        .word_data  (word_data),
        .word_valid (word_valid),
        .rate_we    (rate_we),
        .rate_val   (rate_val),
        .own_done   (own_done)
    );

    cfg_done_tail #(.TAIL_CYCLES(TAIL_CYCLES)) u_tail (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_in      (done_in),
        .fall_p       (fall_p),
        .tail_expired (tail_expired)
    );

    cfg_bypass #(.BYPASS_EN(BYPASS_EN)) u_bypass (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .own_done (own_done),
        .di       (di),
        .dout     (dout)
    );

    // R9
    stop_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> !rise_p);

    // R2
    idle_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !cclk);
endmodule

// File: tb/cfg_serial_master_tb.sv
module cfg_serial_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 4;
    localparam int NB   = 32;
    localparam int WW   = 8;
    localparam int RP   = 8;
    localparam int TAIL = 101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_n = 1'b0;
    logic done_in = 1'b0;
    logic di = 1'b0;
    logic cclk, dout, word_valid;
    logic [WW-1:0] word_data;
    logic cclk_nb, dout_nb, wv_nb;
    logic [WW-1:0] wd_nb;

    int errors = 0;
    int checks = 0;
    int phase = 0;
    int rises = 0;
    int pulse_idx = 0;
    int words_seen = 0;
    bit nb_bad = 1'b0;
    bit finished = 1'b0;
    logic [WW-1:0] exp_words[$];
    logic          exp_byp[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_master #(.DIV_DEFAULT(DIV), .CFG_BITS(NB), .WORD_W(WW), .RATE_POS(RP),
        .TAIL_CYCLES(TAIL), .BYPASS_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .done_in(done_in), .di(di),
        .cclk(cclk), .dout(dout), .word_data(word_data), .word_valid(word_valid));

    cfg_serial_master #(.DIV_DEFAULT(DIV), .CFG_BITS(NB), .WORD_W(WW), .RATE_POS(RP),
        .TAIL_CYCLES(TAIL), .BYPASS_EN(1'b0)) u_nobyp (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .done_in(done_in), .di(di),
        .cclk(cclk_nb), .dout(dout_nb), .word_data(wd_nb), .word_valid(wv_nb));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: send one bit per cclk rise, pushing expectations.
    task automatic send_bit(input logic b, input int pos, inout logic [WW-1:0] acc);
        di = b;
        acc = {acc[WW-2:0], b};
        if (pos < NB && (pos % WW) == WW-1) exp_words.push_back(acc);
        if (pos >= NB) exp_byp.push_back(b);
        @(posedge cclk);
        @(negedge cclk);
        #1;
    endtask

    // Monitor: word scoreboard (R3).
    always @(negedge clk) begin
        if (phase == 1 && word_valid) begin
            words_seen++;
            if (exp_words.size() == 0) begin
                check(1'b0, "R3 unexpected word", int'(word_data), -1);
            end else begin
                logic [WW-1:0] e;
                e = exp_words.pop_front();
                check(word_data == e, "R3 word", int'(word_data), int'(e));
            end
        end
        if (dout_nb !== 1'b0) nb_bad = 1'b1;
    end

    // Monitor: dout before and during bypass (R6, R7).
    always @(posedge cclk) begin
        int r;
        r = rises;
        rises++;
        #1;
        if (phase == 1) begin
            if (r <= NB) begin
                check(dout == 1'b0, "R7 dout idle", int'(dout), 0);
            end else if (exp_byp.size() > 0) begin
                logic e;
                e = exp_byp.pop_front();
                check(dout == e, "R6 bypass bit", int'(dout), int'(e));
            end
        end
    end

    // Monitor: high-phase length of cclk (R4, R5, R10).
    always @(negedge clk) begin
        int h;
        if (cclk) begin
            h++;
        end else if (h > 0) begin
            if (pulse_idx <= 14) begin
                check(h == DIV, phase == 1 ? "R4 default half-period" : "R10 default restored", h, DIV);
            end else if (pulse_idx >= 17) begin
                check(h == (phase == 1 ? 2 : 1), "R5 loaded half-period", h, phase == 1 ? 2 : 1);
            end
            pulse_idx++;
            h = 0;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] acc;
        logic [31:0] own;
        logic [19:0] byp;
        int r0;
        acc = '0;
        own = {8'hA5, 8'h02, 8'h3C, 8'h96};
        byp = 20'hB4E1D;

        // Phase 1: reset state (R1), no start while init_n low (R2).
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(cclk == 0 && dout == 0 && word_valid == 0, "R1 reset outputs", int'({cclk, dout, word_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cclk == 0 && dout == 0 && word_valid == 0, "R1 after reset", int'({cclk, dout, word_valid}), 0);
        repeat (30) @(negedge clk);
        check(rises == 0, "R2 no clock before start", rises, 0);
        phase = 1;
        rises = 0;
        pulse_idx = 0;
        di = own[31];
        init_n = 1'b1;
        for (int i = 0; i < NB; i++) send_bit(own[31-i], i, acc);
        for (int i = 0; i < 20; i++) send_bit(byp[19-i], NB + i, acc);
        for (int i = 0; i < 4; i++) send_bit(1'b0, NB + 20 + i, acc);
        di = 1'b0;

        // Tail after completion (R9).
        r0 = rises;
        done_in = 1'b1;
        repeat (1200) @(negedge clk);
        check((rises - r0) >= TAIL && (rises - r0) <= TAIL + 2, "R9 tail rises", rises - r0, TAIL);
        check(cclk == 1'b0, "R9 parked low", int'(cclk), 0);
        r0 = rises;
        repeat (60) @(negedge clk);
        check(rises == r0, "R9 stays stopped", rises - r0, 0);
        check(words_seen == NB / WW, "R3 word count", words_seen, NB / WW);
        check(exp_words.size() == 0, "R3 words pending", exp_words.size(), 0);
        check(!nb_bad, "R8 no-bypass dout idle", int'(nb_bad), 0);

        // Phase 2: mid-run reset with init_n already high (R2, R10, R5 clamp).
        phase = 2;
        rst_n = 1'b0;
        done_in = 1'b0;
        repeat (3) @(negedge clk);
        check(cclk == 0 && dout == 0, "R1 reset again", int'({cclk, dout}), 0);
        rst_n = 1'b1;
        rises = 0;
        pulse_idx = 0;
        repeat (60) @(negedge clk);
        check(rises == 0, "R2 high level is not a start", rises, 0);
        init_n = 1'b0;
        repeat (3) @(negedge clk);
        init_n = 1'b1;
        while (pulse_idx < 26) @(negedge clk);
        check(rises > 0, "R10 restart", rises, 26);
        check(!nb_bad, "R8 no-bypass dout idle end", int'(nb_bad), 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule